// File: doc/BRIEF.md
# SPI Target Receiver with Header Length Capture

This block is the receive side of an SPI target. While chip-select is low it shifts in serial data (mode 0, most significant bit first), packs it into bytes and sorts each byte into one of two receive queues. Bytes whose position in the frame is below the programmed target count go to the header queue. All later bytes go to the payload queue. At a programmable byte offset it picks up a 16-bit little-endian length field from the header. It raises a valid-length status once the frame holds the target count plus that many payload bytes. When chip-select rises it records an end-detect status and clears its per-frame state. If enabled, it also empties both queues.

A CPU reaches the block through a small synchronous register port. A read returns data one cycle after the access, and a read of a queue removes up to four bytes as one 32-bit word. The receive stream has no back-pressure toward the host. When a queue is full, a per-queue hold bit chooses the outcome. With hold set, the new byte is refused and the stored bytes are kept. With hold clear, the oldest byte is discarded to make room. The three asynchronous SPI pins pass through a two-flop synchronizer, so SCK must run at no more than a quarter of the system clock. A single active-high interrupt combines the unmasked status bits.

Register addresses (`bus_addr`): 0 control (bit0 clear queues on chip-select rise, bit1 header queue hold, bit2 payload queue hold), 1/2 target count high/low byte, 3/4 length offset high/low byte, 5 status (bit0 end-detect, bit1 byte-reach), 6 status mask, 7 valid-length status (bit0), 8 valid-length mask (bit0), 9 length (bits 15:0 value, bit16 captured), 10 header queue word, 11 payload queue word, 12 levels (bits 7:0 header queue, bits 15:8 payload queue).

Top module: `spi_len_rx`

## Requirements
- R1: Bits are sampled on SCK rising edges while chip-select is low and assembled MSB-first. The byte with zero-based frame index i goes to the header queue when i < target count and to the payload queue otherwise.
- R2: The length is the byte at index offset (low half) and the byte at index offset+1 (high half). Register 9 returns it with bit16 set once both bytes have arrived, and reads 0 while no length has been captured.
- R3: Valid-length status (register 7 bit0) sets exactly once per frame, on the first byte after which a length is captured and the byte count is at least target + length. It never sets before that.
- R4: Byte-reach status (register 5 bit1) sets when the byte count of the frame becomes equal to a nonzero target count.
- R5: A chip-select rise sets end-detect (register 5 bit0) and clears the byte count, the partial and captured length, and the captured flag.
- R6: With control bit0 set, a chip-select rise empties both queues. With it clear, the queued bytes survive the rise.
- R7: A queue never holds more than 8 bytes (default depth). When full, a new byte is refused if its hold bit is 1, and the oldest byte is dropped if its hold bit is 0.
- R8: A queue word read removes min(4, level) bytes, with the oldest in bits 7:0 and unfilled lanes reading 0. An empty queue reads 0.
- R9: Status bits are write-one-to-clear, writing 0xFF to register 5 clears both, and a status event in the same cycle as a clear wins.
- R10: Mask bits are 1 to mask and 0 to enable. `irq` is the OR of every status bit whose mask is 0.
- R11: After reset: control 0x7, masks all 1, statuses 0, target and offset 0, queues empty, `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | SPI chip-select, active low (asynchronous) |
| spi_mosi | input | 1 | SPI serial data from the host (asynchronous) |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sends a frame whose length field reaches its threshold several bytes after the header. It checks that valid-length stays clear one byte early, so a design comparing against the target count alone would fire too soon. A zero length placed after the target count must fire as soon as it is captured, which catches an equality test that would never fire. An offset beyond the frame must never capture. Overfilling the payload queue with hold set and then clear separates refusing new data from dropping old data. Reads around chip-select rises, with and without auto-clear, expose state that survives a frame when it should not, or is lost when it should be kept.

// File: rtl/spi_len_rx_pkg.sv
package spi_len_rx_pkg;
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TGT_HI = 4'd1;
  localparam logic [3:0] A_TGT_LO = 4'd2;
  localparam logic [3:0] A_OFS_HI = 4'd3;
  localparam logic [3:0] A_OFS_LO = 4'd4;
  localparam logic [3:0] A_STAT   = 4'd5;
  localparam logic [3:0] A_MASK   = 4'd6;
  localparam logic [3:0] A_VSTAT  = 4'd7;
  localparam logic [3:0] A_VMASK  = 4'd8;
  localparam logic [3:0] A_LEN    = 4'd9;
  localparam logic [3:0] A_HDRQ   = 4'd10;
  localparam logic [3:0] A_PAYQ   = 4'd11;
  localparam logic [3:0] A_LEVEL  = 4'd12;

  typedef struct packed {
    logic hold_pay;
    logic hold_hdr;
    logic auto_clr;
  } ctrl_t;
endpackage

// File: rtl/spi_len_sync.sv
module spi_len_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= INIT;
    end else begin
      chain[0] <= async_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/spi_len_shift.sv
module spi_len_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sck_rise,
  input  logic          sdi,
  output logic          byte_vld,
  output logic [BW-1:0] byte_data
);
  localparam int CW = $clog2(BW);
  logic [CW-1:0] bit_cnt;
  logic [BW-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh      <= {sh[BW-3:0], sdi};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(BW-1)) begin
          byte_vld  <= 1'b1;
          byte_data <= {sh, sdi};
          bit_cnt   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_len_fifo.sv
module spi_len_fifo #(
  parameter int DEPTH = 8,
  parameter int WB = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          pop_word,
  output logic [LW-1:0] level,
  output logic [8*WB-1:0] peek
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] take;
  logic          full, push, drop;

  assign full = (level == LW'(DEPTH));
  assign take = pop_word ? ((level > LW'(WB)) ? LW'(WB) : level) : '0;
  assign drop = wr_en && full && !hold && (take == '0);
  assign push = wr_en && (!full || !hold || (take != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(take) + AW'(drop);
      wr_ptr <= wr_ptr + AW'(push);
      level  <= level + LW'(push) - take - LW'(drop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wr_data;
  end

  for (genvar i = 0; i < WB; i++) begin : g_lane
    assign peek[8*i +: 8] = (LW'(i) < level) ? mem[rd_ptr + AW'(i)] : 8'h00;
  end
endmodule

// File: rtl/spi_len_rx.sv
module spi_len_rx
  import spi_len_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  // pin synchronizer and edge detection
  logic [2:0] pins_s;
  logic       sck_d, cs_d, sck_rise, cs_rise;
  spi_len_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({spi_mosi, spi_cs_n, spi_sck}),
    .sync_o(pins_s)
  );
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pins_s[0];
      cs_d  <= pins_s[1];
    end
  end
  assign sck_rise = pins_s[0] && !sck_d;
  assign cs_rise  = pins_s[1] && !cs_d;

  logic       byte_vld;
  logic [7:0] byte_data;
  spi_len_shift #(.BW(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(!pins_s[1]),
    .sck_rise(sck_rise), .sdi(pins_s[2]),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  // configuration and status registers
  ctrl_t       ctrl_q;
  logic [15:0] tgt_q, ofs_q;
  logic [1:0]  stat_q, mask_q;
  logic        vstat_q, vmask_q;

  // per-frame tracker
  logic [15:0] cnt_q, len_q;
  logic [7:0]  lo_q;
  logic        cap_q, fired_q;
  logic [16:0] cnt_n, need;
  logic [15:0] len_now;
  logic        capturing, lo_hit, valid_evt, reach_evt, to_hdr;

  assign cnt_n     = {1'b0, cnt_q} + 17'd1;
  assign lo_hit    = byte_vld && (cnt_q == ofs_q);
  assign capturing = byte_vld && !cap_q && ({1'b0, cnt_q} == ({1'b0, ofs_q} + 17'd1));
  assign len_now   = capturing ? {byte_data, lo_q} : len_q;
  assign need      = {1'b0, tgt_q} + {1'b0, len_now};
  assign valid_evt = byte_vld && (cap_q || capturing) && !fired_q && (cnt_n >= need);
  assign reach_evt = byte_vld && (cnt_n == {1'b0, tgt_q});
  assign to_hdr    = cnt_q < tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= '0;
      lo_q    <= '0;
      cap_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (cs_rise) begin
      cnt_q   <= '0;
      len_q   <= '0;
      lo_q    <= '0;
      cap_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (byte_vld) begin
      if (cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
      if (lo_hit) lo_q <= byte_data;
      if (capturing) begin
        len_q <= len_now;
        cap_q <= 1'b1;
      end
      if (valid_evt) fired_q <= 1'b1;
    end
  end

  // receive queues
  logic [LW-1:0] lvl_hdr, lvl_pay;
  logic [31:0]   peek_hdr, peek_pay;
  logic          rd_acc, pop_hdr, pop_pay, flush;

  assign rd_acc  = bus_en && !bus_we;
  assign pop_hdr = rd_acc && (bus_addr == A_HDRQ);
  assign pop_pay = rd_acc && (bus_addr == A_PAYQ);
  assign flush   = cs_rise && ctrl_q.auto_clr;

  spi_len_fifo #(.DEPTH(FIFO_DEPTH), .WB(4)) u_hdrq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .hold(ctrl_q.hold_hdr),
    .wr_en(byte_vld && !cs_rise && to_hdr), .wr_data(byte_data),
    .pop_word(pop_hdr), .level(lvl_hdr), .peek(peek_hdr)
  );
  spi_len_fifo #(.DEPTH(FIFO_DEPTH), .WB(4)) u_payq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .hold(ctrl_q.hold_pay),
    .wr_en(byte_vld && !cs_rise && !to_hdr), .wr_data(byte_data),
    .pop_word(pop_pay), .level(lvl_pay), .peek(peek_pay)
  );

  // register writes
  logic wr_acc;
  assign wr_acc = bus_en && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '1;
      tgt_q   <= '0;
      ofs_q   <= '0;
      stat_q  <= '0;
      mask_q  <= '1;
      vstat_q <= 1'b0;
      vmask_q <= 1'b1;
    end else begin
      if (wr_acc) begin
        unique case (bus_addr)
          A_CTRL:   ctrl_q       <= ctrl_t'(bus_wdata[2:0]);
          A_TGT_HI: tgt_q[15:8]  <= bus_wdata;
          A_TGT_LO: tgt_q[7:0]   <= bus_wdata;
          A_OFS_HI: ofs_q[15:8]  <= bus_wdata;
          A_OFS_LO: ofs_q[7:0]   <= bus_wdata;
          A_MASK:   mask_q       <= bus_wdata[1:0];
          A_VMASK:  vmask_q      <= bus_wdata[0];
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~((wr_acc && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b00))
                | {reach_evt && !cs_rise, cs_rise};
      vstat_q <= (vstat_q && !(wr_acc && bus_addr == A_VSTAT && bus_wdata[0]))
                 || (valid_evt && !cs_rise);
    end
  end

  // registered read data
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CTRL:   rd_mux = {29'd0, ctrl_q};
      A_TGT_HI: rd_mux = {24'd0, tgt_q[15:8]};
      A_TGT_LO: rd_mux = {24'd0, tgt_q[7:0]};
      A_OFS_HI: rd_mux = {24'd0, ofs_q[15:8]};
      A_OFS_LO: rd_mux = {24'd0, ofs_q[7:0]};
      A_STAT:   rd_mux = {30'd0, stat_q};
      A_MASK:   rd_mux = {30'd0, mask_q};
      A_VSTAT:  rd_mux = {31'd0, vstat_q};
      A_VMASK:  rd_mux = {31'd0, vmask_q};
      A_LEN:    rd_mux = {15'd0, cap_q, len_q};
      A_HDRQ:   rd_mux = peek_hdr;
      A_PAYQ:   rd_mux = peek_pay;
      A_LEVEL:  rd_mux = {16'd0, 8'(lvl_pay), 8'(lvl_hdr)};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  assign irq = |(stat_q & ~mask_q) || (vstat_q && !vmask_q);
endmodule

// File: rtl/spi_len_rx_chk.sv
module spi_len_rx_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          auto_clr,
  input logic          cap_q,
  input logic          fired_q,
  input logic          valid_evt,
  input logic [1:0]    stat_q,
  input logic [1:0]    mask_q,
  input logic          vstat_q,
  input logic          vmask_q,
  input logic          irq,
  input logic [LW-1:0] lvl_hdr,
  input logic [LW-1:0] lvl_pay
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hdr <= LW'(DEPTH)) && (lvl_pay <= LW'(DEPTH)));

  assert_end_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> stat_q[0]);

  assert_frame_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!cap_q && !fired_q));

  assert_valid_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_evt |=> (vstat_q && fired_q));

  assert_auto_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && auto_clr) |=> (lvl_hdr == '0 && lvl_pay == '0));

  assert_all_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b11 && vmask_q) |-> !irq);
endmodule

bind spi_len_rx spi_len_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .auto_clr(ctrl_q.auto_clr),
  .cap_q(cap_q), .fired_q(fired_q), .valid_evt(valid_evt),
  .stat_q(stat_q), .mask_q(mask_q), .vstat_q(vstat_q), .vmask_q(vmask_q),
  .irq(irq), .lvl_hdr(lvl_hdr), .lvl_pay(lvl_pay)
);

// File: tb/spi_len_rx_test.sv
module spi_len_rx_test;
  localparam int DEPTH = 8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic en = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wd = '0;
  logic [31:0] rdata;
  logic irq;

  spi_len_rx uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .bus_en(en), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
    .bus_rdata(rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit settle = 1'b0, done = 1'b0;

  // behavioural reference state
  logic [7:0] mq0[$], mq1[$];
  int m_cnt = 0, m_lo = 0, m_len = 0, m_tgt = 0, m_ofs = 0;
  bit m_cap = 0, m_fired = 0, m_vstat = 0, m_vmask = 1;
  bit [1:0] m_stat = 0, m_mask = 2'b11;
  bit [2:0] m_ctrl = 3'b111;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_irq();
    return (|(m_stat & ~m_mask)) || (m_vstat && !m_vmask);
  endfunction

  always @(posedge clk) begin
    #2;
    if (settle && !done) chk("R10 irq", {31'd0, irq}, {31'd0, m_irq()});
  end

  function automatic void m_push(input int which, input logic [7:0] b);
    if (which == 0) begin
      if (mq0.size() == DEPTH) begin
        if (m_ctrl[1]) return;
        void'(mq0.pop_front());
      end
      mq0.push_back(b);
    end else begin
      if (mq1.size() == DEPTH) begin
        if (m_ctrl[2]) return;
        void'(mq1.pop_front());
      end
      mq1.push_back(b);
    end
  endfunction

  function automatic void m_byte(input logic [7:0] b);
    int idx = m_cnt;
    m_cnt++;
    m_push((idx < m_tgt) ? 0 : 1, b);
    if (idx == m_ofs) m_lo = b;
    if (!m_cap && idx == m_ofs + 1) begin
      m_len = b * 256 + m_lo;
      m_cap = 1;
    end
    if (m_cnt == m_tgt) m_stat[1] = 1'b1;
    if (m_cap && !m_fired && m_cnt >= m_tgt + m_len) begin
      m_fired = 1;
      m_vstat = 1;
    end
  endfunction

  function automatic logic [31:0] m_pop(input int which);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) begin
      if (which == 0 && mq0.size() > 0) w[8*i +: 8] = mq0.pop_front();
      if (which == 1 && mq1.size() > 0) w[8*i +: 8] = mq1.pop_front();
    end
    return w;
  endfunction

  task automatic spi_byte(input logic [7:0] b);
    settle = 0;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    m_byte(b);
    settle = 1;
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    settle = 0;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    m_stat[0] = 1'b1;
    m_cnt = 0; m_cap = 0; m_fired = 0; m_lo = 0; m_len = 0;
    if (m_ctrl[0]) begin mq0.delete(); mq1.delete(); end
    settle = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    en = 1; we = 1; addr = a; wd = d;
    @(posedge clk);
    #1;
    case (a)
      4'd0: m_ctrl = d[2:0];
      4'd1: m_tgt = (m_tgt & 255) | (d << 8);
      4'd2: m_tgt = (m_tgt & 16'hFF00) | d;
      4'd3: m_ofs = (m_ofs & 255) | (d << 8);
      4'd4: m_ofs = (m_ofs & 16'hFF00) | d;
      4'd5: m_stat = m_stat & ~d[1:0];
      4'd6: m_mask = d[1:0];
      4'd7: if (d[0]) m_vstat = 0;
      4'd8: m_vmask = d[0];
      default: ;
    endcase
    @(negedge clk);
    en = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    en = 1; we = 0; addr = a;
    @(negedge clk);
    en = 0;
    v = rdata;
  endtask

  task automatic send(input logic [7:0] b[]);
    foreach (b[i]) spi_byte(b[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle = 1;
    // R11 reset state
    rd(4'd0, v);  chk("R11 ctrl", v, 32'h7);
    rd(4'd5, v);  chk("R11 stat", v, 32'h0);
    rd(4'd6, v);  chk("R11 mask", v, 32'h3);
    rd(4'd7, v);  chk("R11 vstat", v, 32'h0);
    rd(4'd8, v);  chk("R11 vmask", v, 32'h1);
    rd(4'd12, v); chk("R11 levels", v, 32'h0);
    rd(4'd9, v);  chk("R11 len", v, 32'h0);

    // frame: target 4, length at offset 2 = 3
    wr(4'd0, 8'h06); wr(4'd2, 8'h04); wr(4'd4, 8'h02); wr(4'd6, 8'h00); wr(4'd8, 8'h00);
    cs_lo();
    send('{8'hA0, 8'hA1, 8'h03, 8'h00});
    rd(4'd5, v);  chk("R4 reach at target", v, 32'h2);
    rd(4'd9, v);  chk("R2 length captured", v, 32'h0001_0003);
    send('{8'h55, 8'h66});
    rd(4'd7, v);  chk("R3 not one byte early", v, 32'h0);
    spi_byte(8'h77);
    rd(4'd7, v);  chk("R3 valid at target+len", v, 32'h1);
    rd(4'd12, v); chk("R1 queue split", v, 32'h0304);
    cs_hi();
    rd(4'd5, v);  chk("R5 end detect", v, 32'h3);
    rd(4'd9, v);  chk("R5 length cleared", v, 32'h0);
    rd(4'd12, v); chk("R6 kept without auto clear", v, 32'h0304);
    rd(4'd10, v); chk("R8 header word", v, 32'h0003_A1A0); chk("R1 header model", v, m_pop(0));
    rd(4'd11, v); chk("R8 partial word", v, 32'h0077_6655); chk("R1 payload model", v, m_pop(1));
    rd(4'd11, v); chk("R8 empty read", v, 32'h0); void'(m_pop(1));
    wr(4'd5, 8'h02);
    rd(4'd5, v);  chk("R9 w1c one bit", v, 32'h1);
    wr(4'd7, 8'h01); wr(4'd5, 8'hFF);
    rd(4'd5, v);  chk("R9 ff clears all", v, 32'h0);

    // zero length captured after the target: fires at capture
    wr(4'd0, 8'h07); wr(4'd2, 8'h02);
    cs_lo();
    send('{8'h10, 8'h20, 8'h00});
    rd(4'd7, v);  chk("R3 needs full length", v, 32'h0);
    spi_byte(8'h00);
    rd(4'd7, v);  chk("R3 fires on late capture", v, 32'h1);
    spi_byte(8'h11);
    wr(4'd7, 8'h01);
    spi_byte(8'h12);
    rd(4'd7, v);  chk("R3 only once per frame", v, 32'h0);
    cs_hi();
    rd(4'd12, v); chk("R6 auto clear empties", v, 32'h0);

    // masking
    wr(4'd5, 8'hFF); wr(4'd6, 8'h03); wr(4'd8, 8'h01);
    cs_lo();
    send('{8'h01, 8'h02, 8'h00, 8'h00});
    cs_hi();
    chk("R10 masked irq low", {31'd0, irq}, 32'h0);
    wr(4'd6, 8'h01);
    chk("R10 reach unmasked", {31'd0, irq}, 32'h1);
    wr(4'd5, 8'hFF); wr(4'd7, 8'h01); wr(4'd6, 8'h00); wr(4'd8, 8'h00);

    // full payload queue, hold then overwrite
    wr(4'd2, 8'h00); wr(4'd3, 8'h01); wr(4'd0, 8'h06);
    cs_lo();
    for (int i = 0; i < 10; i++) spi_byte(8'(8'h30 + i));
    rd(4'd12, v); chk("R7 hold caps level", v, 32'h0800);
    rd(4'd9, v);  chk("R2 offset past frame", v, 32'h0);
    cs_hi();
    rd(4'd11, v); chk("R7 hold keeps oldest", v, 32'h3332_3130); void'(m_pop(1));
    rd(4'd11, v); chk("R7 hold keeps oldest", v, 32'h3736_3534); void'(m_pop(1));
    wr(4'd0, 8'h02);
    cs_lo();
    for (int i = 0; i < 10; i++) spi_byte(8'(8'h40 + i));
    cs_hi();
    rd(4'd12, v); chk("R7 overwrite level", v, 32'h0800);
    rd(4'd11, v); chk("R7 overwrite drops oldest", v, 32'h4544_4342); chk("R7 model", v, m_pop(1));
    rd(4'd11, v); chk("R7 overwrite drops oldest", v, 32'h4948_4746); chk("R7 model", v, m_pop(1));
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule